// File: doc/BRIEF.md
# SDRAM Command and Byte-Mask Generator

This block sits between an internal memory requester and the pins of synchronous DRAM on a 32-bit data bus that is split across two chip-select areas. Each request names a command, an area, a byte address, an access size and the byte order. The block turns it into one registered cycle of pin values: chip selects, RAS/CAS/WE, bank and multiplexed address with the auto-precharge bit, four active-low byte masks and the clock-enable. Both areas share every line except their chip select, so devices on both areas can sit on the same wires.

Requests arrive over a valid/ready handshake. The block takes one request per clock while ready is high. Ready drops only while the memory clock is being changed or is unstable. A request held with valid high during that time waits, and it is accepted on the first cycle that ready returns. The power controls drive the clock-enable directly. A self-refresh command leaves clock-enable low until a NOP request brings the devices out again.

Refresh timing, power-up sequencing, read-data capture and bank-state tracking belong to the surrounding controller.

Top module: `sdram_cmd_gen`

## Requirements
- R1: An issued command drives (RAS_n,CAS_n,WE_n) as follows: NOP=111, bank activate=011, read and read-with-precharge=101, write and write-with-precharge=100, precharge-bank and precharge-all=010, auto-refresh and self-refresh=001, mode-register set=000. Request codes: NOP=0, REF=1, SELF=2, PALL=3, PRE=4, ACTV=5, READ=6, READA=7, WRIT=8, WRITA=9, MRS=10.
- R2: Address bit 10 is 1 for read-with-precharge, write-with-precharge and precharge-all, and 0 for read, write and precharge-bank.
- R3: An issued command asserts only chip select `area` (area 0 gives sd_cs_n=2'b10, area 1 gives 2'b01). In a cycle with no issued command both chip selects are high and all four masks are high.
- R4: The byte address splits, from the top down, into row (ROW_W bits), bank (BANK_W), column (COL_W) and byte offset (2). Bank activate places the row on sd_addr. Reads and writes place the column in the low bits of sd_addr. Both drive the bank. Precharge-bank drives the bank. Mode-register set places addr[ROW_W-1:0] on sd_addr with bank 0.
- R5: Little-endian (req_big_endian=0): a byte at offset k drops mask bit k. Sizes are 0=byte, 1=halfword, 2=longword, covering 1, 2 or 4 bytes from the offset.
- R6: Big-endian: a byte at offset k drops mask bit 3-k, so offset 0 maps to mask 3 and offset 3 maps to mask 0.
- R7: A read or write with a misaligned halfword (odd offset), a misaligned longword (nonzero offset) or size 3, and any command code above 10, issues nothing and pulses req_err for one cycle. Masks are driven only for reads and writes; other commands leave them high.
- R8: While freq_chg or clk_unstable is high, req_ready is low, no command is issued, and sd_cke is low in the following cycle. sd_cke returns high the cycle after both inputs fall.
- R9: Self-refresh issues the refresh pattern with sd_cke low in the same cycle, and sd_cke stays low afterwards. While in self-refresh, a NOP request issues a NOP with sd_cke high and ends self-refresh. Any other request is rejected with req_err.
- R10: An accepted request appears on the pins in the cycle after acceptance. Back-to-back requests appear on consecutive cycles. A request offered while ready is low issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_cmd | input | 4 | Command code (R1) |
| req_area | input | 1 | Chip-select area |
| req_addr | input | ROW_W+BANK_W+COL_W+2 | Byte address or mode value |
| req_size | input | 2 | 0 byte, 1 halfword, 2 longword |
| req_big_endian | input | 1 | Byte order for masks |
| freq_chg | input | 1 | Clock frequency change in progress |
| clk_unstable | input | 1 | Clock stopping or restarting |
| req_err | output | 1 | Rejected-request pulse |
| sd_cs_n | output | 2 | Chip selects, one per area |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_bank | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row/column address, bit 10 precharge select |
| sd_dqm_n | output | 4 | Active-low byte masks |
| sd_cke | output | 1 | Clock enable |

## Verification
The hardest state to reach from the ports is self-refresh combined with a pending request. Clock-enable must stay low across idle cycles, a non-NOP request must bounce with an error and leave clock-enable low, and only a NOP may raise it again. The stimulus issues the self-refresh command, idles, offers a read and then a NOP, and checks clock-enable, chip selects and the error pulse after each step. A second scenario holds a request valid through a frequency change to confirm that nothing is issued and that the request is taken once ready returns.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_REF   = 4'd1,
    CMD_SELF  = 4'd2,
    CMD_PALL  = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_ACTV  = 4'd5,
    CMD_READ  = 4'd6,
    CMD_READA = 4'd7,
    CMD_WRIT  = 4'd8,
    CMD_WRITA = 4'd9,
    CMD_MRS   = 4'd10
  } req_cmd_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STB_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam strobe_t STB_ACT  = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam strobe_t STB_RD   = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
  localparam strobe_t STB_WR   = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
  localparam strobe_t STB_PRE  = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam strobe_t STB_REF  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam strobe_t STB_MRS  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam int AP_BIT = 10;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic [3:0]        cmd,
  input  logic [ROW_W-1:0]  row,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  mode,
  output strobe_t           strobe,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] bank_o,
  output logic              known,
  output logic              data_xfer
);
  logic [ROW_W-1:0] col_ext;
  assign col_ext = ROW_W'(col);

  always_comb begin
    strobe    = STB_NOP;
    addr      = '0;
    bank_o    = '0;
    known     = 1'b1;
    data_xfer = 1'b0;
    unique case (cmd)
      CMD_NOP: ;
      CMD_REF, CMD_SELF: strobe = STB_REF;
      CMD_PALL: begin
        strobe       = STB_PRE;
        addr[AP_BIT] = 1'b1;
      end
      CMD_PRE: begin
        strobe = STB_PRE;
        bank_o = bank;
      end
      CMD_ACTV: begin
        strobe = STB_ACT;
        addr   = row;
        bank_o = bank;
      end
      CMD_READ, CMD_READA: begin
        strobe       = STB_RD;
        addr         = col_ext;
        addr[AP_BIT] = (cmd == CMD_READA);
        bank_o       = bank;
        data_xfer    = 1'b1;
      end
      CMD_WRIT, CMD_WRITA: begin
        strobe       = STB_WR;
        addr         = col_ext;
        addr[AP_BIT] = (cmd == CMD_WRITA);
        bank_o       = bank;
        data_xfer    = 1'b1;
      end
      CMD_MRS: begin
        strobe = STB_MRS;
        addr   = mode;
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdram_byte_mask.sv
module sdram_byte_mask #(
  parameter int LANES = 4
) (
  input  logic [1:0]       size,
  input  logic [1:0]       offset,
  input  logic             big_endian,
  output logic [LANES-1:0] mask_n,
  output logic             misaligned
);
  logic [LANES-1:0] span;
  logic [LANES-1:0] le_sel;

  always_comb begin
    misaligned = 1'b0;
    span       = '0;
    case (size)
      2'd0: span = LANES'(4'b0001);
      2'd1: begin
        span       = LANES'(4'b0011);
        misaligned = offset[0];
      end
      2'd2: begin
        span       = LANES'(4'b1111);
        misaligned = (offset != 2'd0);
      end
      default: misaligned = 1'b1;
    endcase
    le_sel = span << offset;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_n[g] = big_endian ? ~le_sel[LANES-1-g] : ~le_sel[g];
  end
endmodule

// File: rtl/sdram_power_ctl.sv
module sdram_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic freq_chg,
  input  logic clk_unstable,
  input  logic enter_self,
  input  logic exit_self,
  output logic in_self,
  output logic cke
);
  logic hold_low;
  assign hold_low = freq_chg | clk_unstable | enter_self | (in_self & ~exit_self);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_self <= 1'b0;
      cke     <= 1'b1;
    end else begin
      cke <= ~hold_low;
      if (enter_self)     in_self <= 1'b1;
      else if (exit_self) in_self <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_gen.sv
module sdram_cmd_gen
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic              req_area,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_big_endian,
  input  logic              freq_chg,
  input  logic              clk_unstable,
  output logic              req_err,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_bank,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [3:0]        sd_dqm_n,
  output logic              sd_cke
);
  localparam int AREAS   = 2;
  localparam int COL_LO  = 2;
  localparam int BANK_LO = COL_LO + COL_W;
  localparam int ROW_LO  = BANK_LO + BANK_W;

  strobe_t           dec_strobe;
  logic [ROW_W-1:0]  dec_addr;
  logic [BANK_W-1:0] dec_bank;
  logic              dec_known;
  logic              dec_xfer;
  logic [3:0]        lane_mask_n;
  logic              lane_misaligned;
  logic              in_self;
  logic              accept;
  logic              illegal;
  logic              issue;
  logic              is_nop;
  logic [AREAS-1:0]  cs_sel_n;

  sdram_cmd_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_decode (
    .cmd       (req_cmd),
    .row       (req_addr[ROW_LO +: ROW_W]),
    .bank      (req_addr[BANK_LO +: BANK_W]),
    .col       (req_addr[COL_LO +: COL_W]),
    .mode      (req_addr[ROW_W-1:0]),
    .strobe    (dec_strobe),
    .addr      (dec_addr),
    .bank_o    (dec_bank),
    .known     (dec_known),
    .data_xfer (dec_xfer)
  );

  sdram_byte_mask #(.LANES(4)) u_mask (
    .size       (req_size),
    .offset     (req_addr[1:0]),
    .big_endian (req_big_endian),
    .mask_n     (lane_mask_n),
    .misaligned (lane_misaligned)
  );

  assign req_ready = ~(freq_chg | clk_unstable);
  assign accept    = req_valid & req_ready;
  assign is_nop    = (req_cmd == CMD_NOP);
  assign illegal   = ~dec_known | (dec_xfer & lane_misaligned) | (in_self & ~is_nop);
  assign issue     = accept & ~illegal;

  sdram_power_ctl u_power (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_chg     (freq_chg),
    .clk_unstable (clk_unstable),
    .enter_self   (issue & (req_cmd == CMD_SELF)),
    .exit_self    (issue & is_nop & in_self),
    .in_self      (in_self),
    .cke          (sd_cke)
  );

  always_comb begin
    for (int a = 0; a < AREAS; a++) begin
      cs_sel_n[a] = ~(issue & (req_area == a[0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_cs_n  <= '1;
      sd_ras_n <= 1'b1;
      sd_cas_n <= 1'b1;
      sd_we_n  <= 1'b1;
      sd_bank  <= '0;
      sd_addr  <= '0;
      sd_dqm_n <= '1;
      req_err  <= 1'b0;
    end else begin
      sd_cs_n <= cs_sel_n;
      req_err <= accept & illegal;
      if (issue) begin
        sd_ras_n <= dec_strobe.ras_n;
        sd_cas_n <= dec_strobe.cas_n;
        sd_we_n  <= dec_strobe.we_n;
        sd_bank  <= dec_bank;
        sd_addr  <= dec_addr;
        sd_dqm_n <= dec_xfer ? lane_mask_n : 4'hF;
      end else begin
        sd_ras_n <= 1'b1;
        sd_cas_n <= 1'b1;
        sd_we_n  <= 1'b1;
        sd_bank  <= '0;
        sd_addr  <= '0;
        sd_dqm_n <= 4'hF;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_gen_chk.sv
module sdram_cmd_gen_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_cmd,
  input logic             freq_chg,
  input logic             clk_unstable,
  input logic             req_err,
  input logic [1:0]       sd_cs_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic [3:0]       sd_dqm_n,
  input logic             sd_cke
);
  assert_one_area_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sd_cs_n) <= 1);

  assert_idle_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n == 2'b11) |-> (sd_dqm_n == 4'hF));

  assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (sd_cs_n == 2'b11));

  assert_cke_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_chg || clk_unstable) |=> !sd_cke);

  assert_ap_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd == 4'd7) |=> (sd_cs_n == 2'b11 || sd_addr[10]));

  assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (sd_cs_n == 2'b11));
endmodule

bind sdram_cmd_gen sdram_cmd_gen_chk #(.ROW_W(ROW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_cmd      (req_cmd),
  .freq_chg     (freq_chg),
  .clk_unstable (clk_unstable),
  .req_err      (req_err),
  .sd_cs_n      (sd_cs_n),
  .sd_addr      (sd_addr),
  .sd_dqm_n     (sd_dqm_n),
  .sd_cke       (sd_cke)
);

// File: tb/sdram_cmd_gen_tb.sv
`timescale 1ns/100ps
module sdram_cmd_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cmd = '0;
  logic        req_area = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_big_endian = 1'b0;
  logic        freq_chg = 1'b0;
  logic        clk_unstable = 1'b0;
  logic        req_err;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_bank;
  logic [11:0] sd_addr;
  logic [3:0]  sd_dqm_n;
  logic        sd_cke;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_area(req_area), .req_addr(req_addr), .req_size(req_size),
    .req_big_endian(req_big_endian), .freq_chg(freq_chg), .clk_unstable(clk_unstable),
    .req_err(req_err), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_bank(sd_bank), .sd_addr(sd_addr), .sd_dqm_n(sd_dqm_n),
    .sd_cke(sd_cke)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_addr(input logic [11:0] row, input logic [1:0] bank,
                                          input logic [7:0] col, input logic [1:0] off);
    return {row, bank, col, off};
  endfunction

  function automatic logic [2:0] exp_stb(input int c);
    case (c)
      5: return 3'b011;
      6, 7: return 3'b101;
      8, 9: return 3'b100;
      3, 4: return 3'b010;
      1, 2: return 3'b001;
      10: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [3:0] exp_mask(input int size, input int off, input bit be);
    logic [3:0] m = 4'hF;
    int n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    for (int k = 0; k < n; k++) begin
      int lane = be ? 3 - (off + k) : off + k;
      m[lane] = 1'b0;
    end
    return m;
  endfunction

  // Drive one request at a falling edge, sample the pins at the next falling edge.
  task automatic send(input int c, input bit area, input logic [23:0] addr,
                      input int size, input bit be);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 4'(c); req_area = area; req_addr = addr;
    req_size = 2'(size); req_big_endian = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 reset cs", 32'(sd_cs_n), 32'h3);
    chk("R3 reset dqm", 32'(sd_dqm_n), 32'hF);
    chk("R8 reset cke", 32'(sd_cke), 32'h1);
    chk("R10 reset ready", 32'(req_ready), 32'h1);
    chk("R7 reset err", 32'(req_err), 32'h0);
  endtask

  task automatic t_cmd_table();
    for (int c = 0; c <= 10; c++) begin
      if (c == 2) continue;
      send(c, 1'b0, mk_addr(12'h0, 2'd1, 8'h11, 2'd0), 2, 1'b0);
      chk($sformatf("R1 strobes cmd %0d", c), 32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'(exp_stb(c)));
      chk($sformatf("R3 cs cmd %0d", c), 32'(sd_cs_n), 32'h2);
      if (c inside {3, 7, 9}) chk($sformatf("R2 a10 high cmd %0d", c), 32'(sd_addr[10]), 32'h1);
      if (c inside {4, 6, 8}) chk($sformatf("R2 a10 low cmd %0d", c), 32'(sd_addr[10]), 32'h0);
    end
  endtask

  task automatic t_areas();
    send(5, 1'b1, mk_addr(12'h123, 2'd2, 8'h0, 2'd0), 0, 1'b0);
    chk("R3 area1 cs", 32'(sd_cs_n), 32'h1);
    chk("R3 non-xfer masks high", 32'(sd_dqm_n), 32'hF);
    idle_cycle();
    chk("R3 idle cs", 32'(sd_cs_n), 32'h3);
    chk("R3 idle dqm", 32'(sd_dqm_n), 32'hF);
  endtask

  task automatic t_addr();
    send(5, 1'b0, mk_addr(12'hABC, 2'd3, 8'h5A, 2'd0), 2, 1'b0);
    chk("R4 actv row", 32'(sd_addr), 32'hABC);
    chk("R4 actv bank", 32'(sd_bank), 32'h3);
    send(6, 1'b0, mk_addr(12'hFFF, 2'd2, 8'hA5, 2'd0), 2, 1'b0);
    chk("R4 read column", 32'(sd_addr), 32'h0A5);
    chk("R4 read bank", 32'(sd_bank), 32'h2);
    send(9, 1'b1, mk_addr(12'h0, 2'd1, 8'h3C, 2'd0), 2, 1'b0);
    chk("R4 writa column", 32'(sd_addr), 32'h43C);
    send(4, 1'b0, mk_addr(12'h0, 2'd2, 8'h0, 2'd0), 0, 1'b0);
    chk("R4 pre bank", 32'(sd_bank), 32'h2);
    send(10, 1'b0, 24'hF00233, 0, 1'b0);
    chk("R4 mrs value", 32'(sd_addr), 32'h233);
    chk("R4 mrs bank", 32'(sd_bank), 32'h0);
  endtask

  task automatic t_lanes(input bit be);
    string tg = be ? "R6" : "R5";
    for (int off = 0; off < 4; off++) begin
      send(8, 1'b0, mk_addr(12'h1, 2'd0, 8'h2, 2'(off)), 0, be);
      chk($sformatf("%s byte off %0d", tg, off), 32'(sd_dqm_n), 32'(exp_mask(0, off, be)));
    end
    for (int off = 0; off < 4; off += 2) begin
      send(6, 1'b0, mk_addr(12'h1, 2'd0, 8'h2, 2'(off)), 1, be);
      chk($sformatf("%s half off %0d", tg, off), 32'(sd_dqm_n), 32'(exp_mask(1, off, be)));
    end
    send(7, 1'b1, mk_addr(12'h1, 2'd0, 8'h2, 2'd0), 2, be);
    chk($sformatf("%s long", tg), 32'(sd_dqm_n), 32'h0);
  endtask

  task automatic t_errors();
    send(6, 1'b0, mk_addr(12'h1, 2'd0, 8'h2, 2'd1), 1, 1'b0);
    chk("R7 odd half err", 32'(req_err), 32'h1);
    chk("R7 odd half cs", 32'(sd_cs_n), 32'h3);
    send(8, 1'b0, mk_addr(12'h1, 2'd0, 8'h2, 2'd2), 2, 1'b0);
    chk("R7 long off2 err", 32'(req_err), 32'h1);
    chk("R7 long off2 cs", 32'(sd_cs_n), 32'h3);
    send(6, 1'b0, mk_addr(12'h1, 2'd0, 8'h2, 2'd0), 3, 1'b0);
    chk("R7 size3 err", 32'(req_err), 32'h1);
    send(12, 1'b1, 24'h0, 0, 1'b0);
    chk("R7 bad code err", 32'(req_err), 32'h1);
    chk("R7 bad code cs", 32'(sd_cs_n), 32'h3);
    idle_cycle();
    chk("R7 err one cycle", 32'(req_err), 32'h0);
    send(5, 1'b0, mk_addr(12'h1, 2'd0, 8'h2, 2'd3), 2, 1'b0);
    chk("R7 size ignored for actv", 32'(sd_cs_n), 32'h2);
  endtask

  task automatic t_power();
    @(negedge clk);
    freq_chg = 1'b1;
    req_valid = 1'b1; req_cmd = 4'd5; req_area = 1'b0; req_addr = '0;
    #0.1;
    chk("R8 ready low freq", 32'(req_ready), 32'h0);
    @(negedge clk);
    chk("R8 cke low freq", 32'(sd_cke), 32'h0);
    chk("R10 no issue while not ready", 32'(sd_cs_n), 32'h3);
    freq_chg = 1'b0; clk_unstable = 1'b1;
    @(negedge clk);
    chk("R8 cke low unstable", 32'(sd_cke), 32'h0);
    chk("R8 no issue unstable", 32'(sd_cs_n), 32'h3);
    clk_unstable = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 cke back high", 32'(sd_cke), 32'h1);
    chk("R10 held request taken", 32'(sd_cs_n), 32'h2);
  endtask

  task automatic t_self();
    send(2, 1'b0, 24'h0, 0, 1'b0);
    chk("R9 self strobes", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'h1);
    chk("R9 self cke low", 32'(sd_cke), 32'h0);
    chk("R9 self cs", 32'(sd_cs_n), 32'h2);
    idle_cycle();
    chk("R9 cke stays low", 32'(sd_cke), 32'h0);
    send(6, 1'b0, 24'h0, 2, 1'b0);
    chk("R9 read rejected err", 32'(req_err), 32'h1);
    chk("R9 read rejected cs", 32'(sd_cs_n), 32'h3);
    chk("R9 cke low after reject", 32'(sd_cke), 32'h0);
    send(0, 1'b1, 24'h0, 0, 1'b0);
    chk("R9 exit cke high", 32'(sd_cke), 32'h1);
    chk("R9 exit nop cs", 32'(sd_cs_n), 32'h1);
    idle_cycle();
    chk("R9 cke high after exit", 32'(sd_cke), 32'h1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 4'd5; req_area = 1'b0; req_addr = mk_addr(12'h055, 2'd1, 8'h0, 2'd0);
    @(negedge clk);
    chk("R10 first on pins", 32'(sd_addr), 32'h055);
    req_cmd = 4'd8; req_area = 1'b1; req_addr = mk_addr(12'h0, 2'd1, 8'h77, 2'd0); req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second on pins", 32'({sd_cs_n, sd_addr}), 32'({2'b01, 12'h077}));
    chk("R10 second strobes", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'h4);
    @(negedge clk);
    chk("R10 then idle", 32'(sd_cs_n), 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_table();
    t_areas();
    t_addr();
    t_lanes(1'b0);
    t_lanes(1'b1);
    t_errors();
    t_power();
    t_self();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule